// File: doc/BRIEF.md
# Serial Command Line Decoder

This block listens to an asynchronous serial line (8 data bits, no parity, one stop bit) and turns typed text lines into commands. A line holds a one-character command, at least one space, a hexadecimal argument of one to four digits, optional trailing spaces, and a line ending. A carriage return or a line feed on its own also ends the line. When a well-formed line ends, the block presents the command byte and the 16-bit argument together with a single-cycle valid pulse. A malformed line produces a single-cycle error pulse, and the rest of that line is ignored.

The serial bit time is a parameter in system clocks. The default of 434 clocks gives 115200 baud from a 50 MHz clock. The incoming line passes through a two-flop synchronizer, and each bit is sampled at its midpoint. The block is meant to sit behind a host-side terminal or controller that drives the line.

Top module: `cmdline_parser`

## Requirements
- R1: While reset is held and right after it is released, cmdValid and cmdError are low and cmdCode and cmdParam are zero.
- R2: Frames are received with a low start bit, eight data bits sent least significant bit first, and a high stop bit. Each bit lasts CLKS_PER_BIT clocks and is sampled at its midpoint. A low pulse that is no longer low at the middle of the start bit produces no byte.
- R3: The first character of a line that is not a space (0x20) becomes the command. Leading spaces produce no output, and so does an empty line made of CR (0x0D) and/or LF (0x0A) alone.
- R4: The command character must be followed by a space. Any other character in that position gives an error.
- R5: The characters 0x30-0x39, 0x41-0x46 and 0x61-0x66 are hex digits worth 0-9, 10-15 and 10-15. Each digit shifts the argument left by four bits and places the digit in the low nibble, so one to four digits give their zero-extended value.
- R6: Extra spaces between the command and the argument, and spaces after the argument, are ignored.
- R7: A CR or an LF that follows at least one digit completes the line. On the clock after the receiver delivers the terminating byte, cmdValid pulses for one cycle, and cmdCode and cmdParam take the line's values and hold them until the next valid line. The other character of a CR/LF pair then counts as an empty line.
- R8: A fifth hex digit gives an error.
- R9: An error is also raised by a character in the argument field that is neither a space, a hex digit nor a terminator, by a digit that follows a trailing space, and by a terminator that comes before any digit.
- R10: After an error the block ignores bytes up to the next CR or LF, and cmdCode and cmdParam keep their previous values. The line after that is decoded normally.
- R11: cmdValid and cmdError each last one clock and are never high together. A line that has not been terminated produces neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| serialIn | input | 1 | Asynchronous serial receive line, idle high |
| cmdCode | output | 8 | Command byte of the last valid line |
| cmdParam | output | 16 | Argument of the last valid line |
| cmdValid | output | 1 | One-cycle pulse when a valid line completes |
| cmdError | output | 1 | One-cycle pulse when a line is rejected |

## Verification
The receiver delivers a byte one clock after it samples the middle of the stop bit, and the decoder registers its result one clock later. Any valid or error pulse therefore appears about half a bit time into the stop bit of the byte that decides it, well before that frame ends. The bench counts pulses on falling edges. It compares the counts and values at the falling edge right after the last stop bit of a line has been driven. It then waits three more bit times and confirms that nothing further has appeared. For the false-start and unterminated-line cases, the check comes after a quiet gap of at least one frame.

// File: rtl/cmdline_pkg.sv
package cmdline_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rxState_t;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_AFTERCMD,
    PS_PRE,
    PS_DIGITS,
    PS_TRAIL,
    PS_DISCARD
  } parseState_t;

  typedef enum logic [2:0] {
    CH_SPACE,
    CH_CR,
    CH_LF,
    CH_HEX,
    CH_OTHER
  } charClass_t;

  // strobes from the line controller to the datapath
  typedef struct packed {
    logic loadCmd;
    logic shiftDigit;
    logic commit;
    logic flagError;
  } dpCtrl_t;

  localparam logic [7:0] ASCII_SPACE = 8'h20;
  localparam logic [7:0] ASCII_CR    = 8'h0D;
  localparam logic [7:0] ASCII_LF    = 8'h0A;

endpackage

// File: rtl/cmdline_rx.sv
module cmdline_rx
  import cmdline_pkg::*;
#(
  parameter int CLKS_PER_BIT = 434,
  parameter int DATA_BITS    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serialIn,
  output logic                 byteValid,
  output logic [DATA_BITS-1:0] byteData
);

  localparam int CNT_W  = $clog2(CLKS_PER_BIT);
  localparam int BIT_W  = $clog2(DATA_BITS);
  localparam int HALF   = CLKS_PER_BIT / 2;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CLKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(HALF - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_BITS - 1);

  logic [1:0]           syncFf;
  logic                 rxLine;
  rxState_t             state;
  logic [CNT_W-1:0]     tickCnt;
  logic [BIT_W-1:0]     bitCnt;
  logic [DATA_BITS-1:0] shiftReg;

  assign rxLine = syncFf[1];

  always_ff @(posedge clk) begin
    if (!rstN) syncFf <= 2'b11;
    else       syncFf <= {syncFf[0], serialIn};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= RX_IDLE;
      tickCnt   <= '0;
      bitCnt    <= '0;
      shiftReg  <= '0;
      byteValid <= 1'b0;
      byteData  <= '0;
    end else begin
      byteValid <= 1'b0;
      case (state)
        RX_IDLE: begin
          tickCnt <= '0;
          if (!rxLine) state <= RX_START;
        end
        RX_START: begin
          if (tickCnt == CNT_HALF) begin
            tickCnt <= '0;
            bitCnt  <= '0;
            state   <= rxLine ? RX_IDLE : RX_DATA;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (tickCnt == CNT_FULL) begin
            tickCnt  <= '0;
            shiftReg <= {rxLine, shiftReg[DATA_BITS-1:1]};
            if (bitCnt == BIT_LAST) state <= RX_STOP;
            else                    bitCnt <= bitCnt + 1'b1;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (tickCnt == CNT_FULL) begin
            tickCnt <= '0;
            state   <= RX_IDLE;
            if (rxLine) begin
              byteValid <= 1'b1;
              byteData  <= shiftReg;
            end
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // R2: a delivered byte always had its stop bit sampled high
  a_r2_stop_high: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> $past(rxLine));

  // R2: a rejected start never reaches the data phase
  a_r2_false_start: assert property (@(posedge clk) disable iff (!rstN)
    (state == RX_START && tickCnt == CNT_HALF && rxLine) |=> state == RX_IDLE);

endmodule

// File: rtl/cmdline_dp.sv
module cmdline_dp
  import cmdline_pkg::*;
#(
  parameter int PARAM_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [7:0]         byteData,
  input  dpCtrl_t            ctrl,
  output charClass_t         charClass,
  output logic               digitFull,
  output logic [7:0]         cmdCode,
  output logic [PARAM_W-1:0] cmdParam,
  output logic               cmdValid,
  output logic               cmdError
);

  localparam int MAX_DIGITS = PARAM_W / 4;
  localparam int DCNT_W     = $clog2(MAX_DIGITS + 1);
  localparam logic [DCNT_W-1:0] DCNT_MAX = DCNT_W'(MAX_DIGITS);

  logic [3:0]         nibble;
  logic [7:0]         cmdWork;
  logic [PARAM_W-1:0] paramAcc;
  logic [DCNT_W-1:0]  digitCnt;

  always_comb begin
    nibble    = 4'h0;
    charClass = CH_OTHER;
    if (byteData == ASCII_SPACE) begin
      charClass = CH_SPACE;
    end else if (byteData == ASCII_CR) begin
      charClass = CH_CR;
    end else if (byteData == ASCII_LF) begin
      charClass = CH_LF;
    end else if (byteData >= 8'h30 && byteData <= 8'h39) begin
      charClass = CH_HEX;
      nibble    = byteData[3:0];
    end else if ((byteData >= 8'h41 && byteData <= 8'h46) ||
                 (byteData >= 8'h61 && byteData <= 8'h66)) begin
      charClass = CH_HEX;
      nibble    = byteData[3:0] + 4'd9;
    end
  end

  assign digitFull = (digitCnt == DCNT_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdWork  <= '0;
      paramAcc <= '0;
      digitCnt <= '0;
      cmdCode  <= '0;
      cmdParam <= '0;
      cmdValid <= 1'b0;
      cmdError <= 1'b0;
    end else begin
      cmdValid <= ctrl.commit;
      cmdError <= ctrl.flagError;
      if (ctrl.loadCmd) begin
        cmdWork  <= byteData;
        paramAcc <= '0;
        digitCnt <= '0;
      end else if (ctrl.shiftDigit) begin
        paramAcc <= {paramAcc[PARAM_W-5:0], nibble};
        digitCnt <= digitCnt + 1'b1;
      end
      if (ctrl.commit) begin
        cmdCode  <= cmdWork;
        cmdParam <= paramAcc;
      end
    end
  end

  // R8: the digit counter never passes the argument width
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    digitCnt <= DCNT_MAX);

  // R8: the controller never requests a shift into a full argument
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.shiftDigit |-> !digitFull);

  // R10: outputs move only on a commit
  a_r10_hold_outputs: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctrl.commit) |-> $stable(cmdCode) && $stable(cmdParam));

endmodule

// File: rtl/cmdline_ctrl.sv
module cmdline_ctrl
  import cmdline_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  input  charClass_t charClass,
  input  logic       digitFull,
  output dpCtrl_t    ctrl
);

  parseState_t state, nextState;
  logic        isTerm;

  assign isTerm = (charClass == CH_CR) || (charClass == CH_LF);

  always_comb begin
    nextState = state;
    ctrl      = '0;
    if (byteValid) begin
      case (state)
        PS_IDLE: begin
          if (charClass != CH_SPACE && !isTerm) begin
            ctrl.loadCmd = 1'b1;
            nextState    = PS_AFTERCMD;
          end
        end
        PS_AFTERCMD: begin
          if (charClass == CH_SPACE) begin
            nextState = PS_PRE;
          end else begin
            ctrl.flagError = 1'b1;
            nextState      = isTerm ? PS_IDLE : PS_DISCARD;
          end
        end
        PS_PRE: begin
          if (charClass == CH_HEX) begin
            ctrl.shiftDigit = 1'b1;
            nextState       = PS_DIGITS;
          end else if (charClass != CH_SPACE) begin
            ctrl.flagError = 1'b1;
            nextState      = isTerm ? PS_IDLE : PS_DISCARD;
          end
        end
        PS_DIGITS: begin
          if (charClass == CH_HEX) begin
            if (digitFull) begin
              ctrl.flagError = 1'b1;
              nextState      = PS_DISCARD;
            end else begin
              ctrl.shiftDigit = 1'b1;
            end
          end else if (charClass == CH_SPACE) begin
            nextState = PS_TRAIL;
          end else if (isTerm) begin
            ctrl.commit = 1'b1;
            nextState   = PS_IDLE;
          end else begin
            ctrl.flagError = 1'b1;
            nextState      = PS_DISCARD;
          end
        end
        PS_TRAIL: begin
          if (isTerm) begin
            ctrl.commit = 1'b1;
            nextState   = PS_IDLE;
          end else if (charClass != CH_SPACE) begin
            ctrl.flagError = 1'b1;
            nextState      = PS_DISCARD;
          end
        end
        PS_DISCARD: begin
          if (isTerm) nextState = PS_IDLE;
        end
        default: nextState = PS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= PS_IDLE;
    else       state <= nextState;
  end

  // R10: non-terminator bytes keep the parser discarding
  a_r10_discard_stays: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_DISCARD && byteValid && !isTerm) |=> state == PS_DISCARD);

  // R11: nothing is emitted while a line is being discarded
  a_r11_discard_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_DISCARD) |-> !ctrl.commit && !ctrl.flagError);

  // R11: strobes only arise from a received byte
  a_r11_byte_driven: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.commit || ctrl.flagError) |-> byteValid);

endmodule

// File: rtl/cmdline_parser.sv
module cmdline_parser
  import cmdline_pkg::*;
#(
  parameter int CLKS_PER_BIT = 434,
  parameter int PARAM_W      = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               serialIn,
  output logic [7:0]         cmdCode,
  output logic [PARAM_W-1:0] cmdParam,
  output logic               cmdValid,
  output logic               cmdError
);

  logic       rxValid;
  logic [7:0] rxByte;
  charClass_t charClass;
  logic       digitFull;
  dpCtrl_t    ctrl;

  cmdline_rx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_BITS(8)) u_rx (
    .clk      (clk),
    .rstN     (rstN),
    .serialIn (serialIn),
    .byteValid(rxValid),
    .byteData (rxByte)
  );

  cmdline_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .byteValid(rxValid),
    .charClass(charClass),
    .digitFull(digitFull),
    .ctrl     (ctrl)
  );

  cmdline_dp #(.PARAM_W(PARAM_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .byteData (rxByte),
    .ctrl     (ctrl),
    .charClass(charClass),
    .digitFull(digitFull),
    .cmdCode  (cmdCode),
    .cmdParam (cmdParam),
    .cmdValid (cmdValid),
    .cmdError (cmdError)
  );

  // R11: the two strobes never coincide
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && cmdError));

  // R11: each strobe lasts a single cycle
  a_r11_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);
  a_r11_error_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cmdError |=> !cmdError);

  // R7: a commit is always caused by a terminator byte one clock earlier
  a_r7_commit_on_term: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> $past(rxValid) &&
                 ($past(rxByte) == ASCII_CR || $past(rxByte) == ASCII_LF));

endmodule

// File: tb/cmdline_parser_test.sv
module cmdline_parser_test;

  localparam int CPB      = 16;
  localparam int N_VEC    = 12;
  localparam int WATCHDOG = 150000;

  typedef struct packed {
    logic [95:0] text;
    logic [3:0]  len;
    logic [1:0]  kind;   // 0 none, 1 valid, 2 error
    logic [7:0]  code;
    logic [15:0] prm;
  } vec_t;

  localparam vec_t VECS [N_VEC] = '{
    '{"A 1F2E\015\012",       4'd8,  2'd1, 8'h41, 16'h1F2E},
    '{"s   00ff  \015\012",   4'd12, 2'd1, 8'h73, 16'h00FF},
    '{"B 7\012",              4'd4,  2'd1, 8'h42, 16'h0007},
    '{"C 12\015",             4'd5,  2'd1, 8'h43, 16'h0012},
    '{"D 12345\015\012",      4'd9,  2'd2, 8'h00, 16'h0000},
    '{"E 12G4\015\012",       4'd8,  2'd2, 8'h00, 16'h0000},
    '{"F \015\012",           4'd4,  2'd2, 8'h00, 16'h0000},
    '{"G12\015\012",          4'd5,  2'd2, 8'h00, 16'h0000},
    '{"  H abcd\015\012",     4'd10, 2'd1, 8'h48, 16'hABCD},
    '{"\015\012",             4'd2,  2'd0, 8'h00, 16'h0000},
    '{"J 1 2\015\012",        4'd7,  2'd2, 8'h00, 16'h0000},
    '{"K FFFF \015\012",      4'd9,  2'd1, 8'h4B, 16'hFFFF}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serialIn = 1'b1;
  logic [7:0]  cmdCode;
  logic [15:0] cmdParam;
  logic        cmdValid;
  logic        cmdError;

  int checks = 0;
  int errors = 0;
  int nValid = 0;
  int nError = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  cmdline_parser #(.CLKS_PER_BIT(CPB), .PARAM_W(16)) uut (
    .clk     (clk),
    .rstN    (rstN),
    .serialIn(serialIn),
    .cmdCode (cmdCode),
    .cmdParam(cmdParam),
    .cmdValid(cmdValid),
    .cmdError(cmdError)
  );

  always @(negedge clk) begin
    if (rstN && cmdValid) nValid <= nValid + 1;
    if (rstN && cmdError) nError <= nError + 1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    serialIn = 1'b0;
    repeat (CPB) @(posedge clk);
    for (int k = 0; k < 8; k++) begin
      serialIn = b[k];
      repeat (CPB) @(posedge clk);
    end
    serialIn = 1'b1;
    repeat (CPB) @(posedge clk);
  endtask

  task automatic sendText(input vec_t v);
    for (int i = 0; i < int'(v.len); i++)
      sendByte(v.text[8*(int'(v.len)-1-i) +: 8]);
  endtask

  int   baseV;
  int   baseE;
  logic [7:0]  expCode;
  logic [15:0] expParam;

  initial begin
    expCode  = 8'h00;
    expParam = 16'h0000;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!cmdValid && !cmdError, "R1 strobes in reset", {cmdValid, cmdError}, 0);
    check(cmdCode == 8'h00 && cmdParam == 16'h0, "R1 outputs in reset",
          {cmdCode, cmdParam}, 0);
    @(posedge clk);
    rstN = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(!cmdValid && !cmdError && cmdCode == 8'h00 && cmdParam == 16'h0,
          "R1 after release", {cmdValid, cmdError, cmdCode, cmdParam}, 0);

    // table of lines: R3 R4 R5 R6 R7 R8 R9 R10
    for (int n = 0; n < N_VEC; n++) begin
      baseV = nValid;
      baseE = nError;
      sendText(VECS[n]);
      @(negedge clk);
      // result due inside the last stop bit
      check(nValid - baseV == (VECS[n].kind == 2'd1 ? 1 : 0),
            $sformatf("R7 valid count line %0d", n), nValid - baseV,
            VECS[n].kind == 2'd1 ? 1 : 0);
      check(nError - baseE == (VECS[n].kind == 2'd2 ? 1 : 0),
            $sformatf("R9 error count line %0d", n), nError - baseE,
            VECS[n].kind == 2'd2 ? 1 : 0);
      if (VECS[n].kind == 2'd1) begin
        expCode  = VECS[n].code;
        expParam = VECS[n].prm;
      end
      check(cmdCode == expCode, $sformatf("R5 code line %0d", n), cmdCode, expCode);
      check(cmdParam == expParam, $sformatf("R5 param line %0d", n), cmdParam, expParam);
      repeat (3*CPB) @(posedge clk);
      @(negedge clk);
      check(nValid - baseV <= 1 && nError - baseE <= 1,
            $sformatf("R11 no late strobe line %0d", n),
            (nValid - baseV) + (nError - baseE), 1);
    end

    // R11: unterminated line stays silent, then the terminator commits it
    baseV = nValid;
    baseE = nError;
    sendByte(8'h5A); sendByte(8'h20); sendByte(8'h39);
    repeat (20*CPB) @(posedge clk);
    @(negedge clk);
    check(nValid == baseV && nError == baseE, "R11 no output before terminator",
          (nValid - baseV) + (nError - baseE), 0);
    sendByte(8'h0A);
    @(negedge clk);
    check(nValid - baseV == 1 && cmdCode == 8'h5A && cmdParam == 16'h0009,
          "R7 late terminator commits", {cmdCode, cmdParam}, {8'h5A, 16'h0009});

    // R2: a short low glitch is no start bit
    baseV = nValid;
    baseE = nError;
    serialIn = 1'b0;
    repeat (3) @(posedge clk);
    serialIn = 1'b1;
    repeat (2*CPB) @(posedge clk);
    sendText('{"M 5\012", 4'd4, 2'd1, 8'h4D, 16'h0005});
    @(negedge clk);
    check(nValid - baseV == 1 && nError == baseE, "R2 glitch rejected count",
          nValid - baseV, 1);
    check(cmdCode == 8'h4D && cmdParam == 16'h0005, "R2 glitch rejected value",
          {cmdCode, cmdParam}, {8'h4D, 16'h0005});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule